// File: doc/BRIEF.md
# Indexed Address Translation Window Bank

This block holds two sets of programmable address translation windows, one for inbound traffic and one for outbound traffic, each with `NUM_WIN` windows. Software never addresses a window directly. It first writes a selector register that names one window and a direction. It then reaches that window's control, base, limit and target registers through a single shared group of register offsets. Each window keeps two copies of its settings. One copy is what software writes and reads back. The other copy is what the lookup logic uses, and it is refreshed only when software writes the second control register.

On the lookup side, a 64-bit address and a direction flag are presented for one cycle. The address is compared against every enabled window of that direction, and the lowest-numbered window that hits wins. A memory-type window returns a translated address. An outbound configuration-type window instead returns a bus number, a device/function number and an offset within configuration space. An outbound address that hits no window is flagged as a miss.

After reset, inbound window 0 is enabled and maps the low 4 GiB onto itself, so inbound traffic passes through untranslated before any software setup.

Top module: `xlat_window_bank`

## Requirements
- R1: The selector register sits at offset 0x900 and reads back the full 32-bit value last written to it. Bits 3:0 give the window index and bit 31 picks the inbound set (1) or the outbound set (0). While the index is `NUM_WIN` or more, writes to window registers are dropped and reads of them return 0.
- R2: The window registers act on the selected window at these offsets: 0x904 type control, 0x908 enable control, 0x90C base bits 31:0, 0x910 base bits 63:32, 0x914 limit, 0x918 target bits 31:0, 0x91C target bits 63:32. Each one reads back the value last written. Writing one 32-bit half of base or target leaves the other half unchanged.
- R3: After reset, every window has base 0, target 0, limit 0xFFFFFFFF, type control 0 and enable control 0. The one exception is inbound window 0, whose enable control is 0x80000000 and which is active, so inbound addresses below 4 GiB map to themselves.
- R4: Lookups use only the settings that were current at the last write to the enable control (0x908). At that write, bit 31 of the written value becomes the window's enable, and the base, limit, target and type held at that moment become active. Writes to the other registers have no effect on lookups until the next such write.
- R5: A window hits when base <= address <= {base[63:32], limit}. A memory-window hit reports the translated address target + (address - base).
- R6: An outbound window whose committed type control is non-zero is a configuration window. A hit on it reports the bus number from target bits 31:24, the device/function from target bits 23:16, and the offset as the low `CFG_OFF_W` bits of (address - base). The translated address reads 0 in that case. Inbound windows always translate as memory windows, whatever their type control.
- R7: When a window is committed with a changed type, it decodes only as the new type. A window changed from configuration to memory returns a translated address and no configuration fields.
- R8: When several enabled windows of the requested direction hit, the result names the lowest-numbered window and uses its translation.
- R9: An outbound lookup that hits no window raises the miss output. An inbound lookup that hits no window raises neither the hit output nor the miss output.
- R10: A lookup result appears on the result outputs exactly one cycle after the lookup valid input. A commit written in the same cycle as a lookup does not affect that lookup's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register offset, used for both reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| lk_valid | input | 1 | Lookup request valid |
| lk_inbound | input | 1 | Lookup direction: 1 inbound, 0 outbound |
| lk_addr | input | 64 | Address to translate |
| res_valid | output | 1 | Result valid, one cycle after `lk_valid` |
| res_hit | output | 1 | Some enabled window matched |
| res_miss | output | 1 | Outbound lookup matched no window |
| res_cfg | output | 1 | Hit was on an outbound configuration window |
| res_win | output | 4 | Index of the winning window |
| res_addr | output | 64 | Translated address on a memory hit, 0 otherwise |
| res_bus | output | 8 | Bus number on a configuration hit |
| res_devfn | output | 8 | Device/function on a configuration hit |
| res_off | output | CFG_OFF_W | Configuration-space offset on a configuration hit |

## Verification
A write to the enable control of a window and a lookup that this window decides can arrive in the same clock cycle. The bench drives both on one edge: it disables the lower-numbered of two overlapping outbound windows while looking up an address inside both. The result for that lookup must still name the old winner with the old translation. The lookup one cycle later must fall through to the higher-numbered window. The bench also interleaves uncommitted edits with lookups, to show that staged values stay invisible until the enable control is written.

// File: rtl/xlat_window_bank.sv
module xlat_window_bank #(
  parameter int NUM_WIN   = 4,
  parameter int CFG_OFF_W = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic [11:0]          reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  input  logic                 lk_valid,
  input  logic                 lk_inbound,
  input  logic [63:0]          lk_addr,
  output logic                 res_valid,
  output logic                 res_hit,
  output logic                 res_miss,
  output logic                 res_cfg,
  output logic [3:0]           res_win,
  output logic [63:0]          res_addr,
  output logic [7:0]           res_bus,
  output logic [7:0]           res_devfn,
  output logic [CFG_OFF_W-1:0] res_off
);
  localparam int NW2 = 2 * NUM_WIN;
  localparam int FW  = $clog2(NW2);
  localparam int IW  = $clog2(NUM_WIN);

  localparam logic [11:0] A_SEL  = 12'h900;
  localparam logic [11:0] A_TYPE = 12'h904;
  localparam logic [11:0] A_ENA  = 12'h908;
  localparam logic [11:0] A_BLO  = 12'h90C;
  localparam logic [11:0] A_BHI  = 12'h910;
  localparam logic [11:0] A_LIM  = 12'h914;
  localparam logic [11:0] A_TLO  = 12'h918;
  localparam logic [11:0] A_THI  = 12'h91C;

  // selector and staged (software-visible) copies
  logic [31:0] sel_q;
  logic [31:0] s_type [NW2];
  logic [31:0] s_ena  [NW2];
  logic [31:0] s_lim  [NW2];
  logic [63:0] s_base [NW2];
  logic [63:0] s_tgt  [NW2];

  // committed (lookup-visible) copies
  logic [NW2-1:0] c_en;
  logic [NW2-1:0] c_cfg;
  logic [31:0]    c_lim  [NW2];
  logic [63:0]    c_base [NW2];
  logic [63:0]    c_tgt  [NW2];

  logic          sel_ok;
  logic [FW-1:0] sel;

  assign sel_ok = 32'(sel_q[3:0]) < 32'(NUM_WIN);
  assign sel    = sel_q[31] ? FW'(NUM_WIN) + FW'(sel_q[3:0]) : FW'(sel_q[3:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      c_en  <= NW2'(1) << NUM_WIN;
      c_cfg <= '0;
      for (int w = 0; w < NW2; w++) begin
        s_type[w] <= '0;
        s_ena[w]  <= (w == NUM_WIN) ? 32'h8000_0000 : 32'h0;
        s_lim[w]  <= 32'hFFFF_FFFF;
        s_base[w] <= '0;
        s_tgt[w]  <= '0;
        c_lim[w]  <= 32'hFFFF_FFFF;
        c_base[w] <= '0;
        c_tgt[w]  <= '0;
      end
    end else if (reg_wr) begin
      if (reg_addr == A_SEL) begin
        sel_q <= reg_wdata;
      end else if (sel_ok) begin
        case (reg_addr)
          A_TYPE: s_type[sel] <= reg_wdata;
          A_ENA: begin
            s_ena[sel]  <= reg_wdata;
            c_en[sel]   <= reg_wdata[31];
            c_cfg[sel]  <= !sel_q[31] && (s_type[sel] != 32'h0);
            c_base[sel] <= s_base[sel];
            c_lim[sel]  <= s_lim[sel];
            c_tgt[sel]  <= s_tgt[sel];
          end
          A_BLO:  s_base[sel][31:0]  <= reg_wdata;
          A_BHI:  s_base[sel][63:32] <= reg_wdata;
          A_LIM:  s_lim[sel]         <= reg_wdata;
          A_TLO:  s_tgt[sel][31:0]   <= reg_wdata;
          A_THI:  s_tgt[sel][63:32]  <= reg_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_SEL) begin
      reg_rdata = sel_q;
    end else if (sel_ok) begin
      case (reg_addr)
        A_TYPE: reg_rdata = s_type[sel];
        A_ENA:  reg_rdata = s_ena[sel];
        A_BLO:  reg_rdata = s_base[sel][31:0];
        A_BHI:  reg_rdata = s_base[sel][63:32];
        A_LIM:  reg_rdata = s_lim[sel];
        A_TLO:  reg_rdata = s_tgt[sel][31:0];
        A_THI:  reg_rdata = s_tgt[sel][63:32];
        default: reg_rdata = '0;
      endcase
    end
  end

  // per-window range compare
  logic [NW2-1:0] w_hit;
  for (genvar w = 0; w < NW2; w++) begin : g_win
    assign w_hit[w] = c_en[w] && (lk_addr >= c_base[w]) &&
                      (lk_addr <= {c_base[w][63:32], c_lim[w]});
  end

  logic [NUM_WIN-1:0] d_hit;
  assign d_hit = lk_inbound ? w_hit[NW2-1:NUM_WIN] : w_hit[NUM_WIN-1:0];

  logic          found;
  logic [IW-1:0] win;
  always_comb begin
    found = 1'b0;
    win   = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (d_hit[i]) begin
        found = 1'b1;
        win   = IW'(i);
      end
    end
  end

  logic [FW-1:0] fsel;
  logic [63:0]   rel, xa;
  logic          is_cfg, mem_hit, cfg_hit;

  assign fsel    = lk_inbound ? FW'(NUM_WIN) + FW'(win) : FW'(win);
  assign rel     = lk_addr - c_base[fsel];
  assign xa      = c_tgt[fsel] + rel;
  assign is_cfg  = c_cfg[fsel];
  assign mem_hit = lk_valid && found && !is_cfg;
  assign cfg_hit = lk_valid && found && is_cfg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_miss  <= 1'b0;
      res_cfg   <= 1'b0;
      res_win   <= '0;
      res_addr  <= '0;
      res_bus   <= '0;
      res_devfn <= '0;
      res_off   <= '0;
    end else begin
      res_valid <= lk_valid;
      res_hit   <= lk_valid && found;
      res_miss  <= lk_valid && !lk_inbound && !found;
      res_cfg   <= cfg_hit;
      res_win   <= (lk_valid && found) ? 4'(win) : 4'h0;
      res_addr  <= mem_hit ? xa : 64'h0;
      res_bus   <= cfg_hit ? c_tgt[fsel][31:24] : 8'h0;
      res_devfn <= cfg_hit ? c_tgt[fsel][23:16] : 8'h0;
      res_off   <= cfg_hit ? rel[CFG_OFF_W-1:0] : '0;
    end
  end

  // R9
  hit_miss_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_hit |-> !res_miss);

  // R9
  miss_outbound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_miss |-> $past(lk_valid && !lk_inbound));

  // R6
  cfg_outbound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_cfg |-> (res_hit && !$past(lk_inbound)));

  // R6
  cfg_fields_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !res_cfg |-> (res_bus == 8'h0 && res_devfn == 8'h0));

  // R4
  commit_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == A_ENA) |=> ($stable(c_en) && $stable(c_cfg)));

  // R1
  bad_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !sel_ok && reg_addr != A_SEL) |=> $stable(c_en));
endmodule

// File: tb/sim_xlat_window_bank.sv
module sim_xlat_window_bank;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        lk_valid = 1'b0, lk_inbound = 1'b0;
  logic [63:0] lk_addr = '0;
  logic        res_valid, res_hit, res_miss, res_cfg;
  logic [3:0]  res_win;
  logic [63:0] res_addr;
  logic [7:0]  res_bus, res_devfn;
  logic [11:0] res_off;

  xlat_window_bank #(.NUM_WIN(4), .CFG_OFF_W(12)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_valid(lk_valid),
    .lk_inbound(lk_inbound), .lk_addr(lk_addr), .res_valid(res_valid),
    .res_hit(res_hit), .res_miss(res_miss), .res_cfg(res_cfg),
    .res_win(res_win), .res_addr(res_addr), .res_bus(res_bus),
    .res_devfn(res_devfn), .res_off(res_off));

  typedef struct {
    logic        hit, miss, cfg;
    logic [3:0]  win;
    logic [63:0] addr;
    logic [7:0]  bus, devfn;
    logic [11:0] off;
    string       tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  function automatic exp_t mk(input logic h, input logic m, input logic c,
                              input logic [3:0] w, input logic [63:0] a,
                              input logic [7:0] b, input logic [7:0] d,
                              input logic [11:0] o, input string t);
    exp_t e;
    e.hit = h; e.miss = m; e.cfg = c; e.win = w; e.addr = a;
    e.bus = b; e.devfn = d; e.off = o; e.tag = t;
    return e;
  endfunction

  always @(negedge clk) begin : monitor
    exp_t e;
    if (rst_n && res_valid) begin
      checks++;
      if (q.size() == 0) begin
        errors++;
        $display("FAIL R10: result with no pending lookup, got valid=1 expected valid=0");
      end else begin
        e = q.pop_front();
        if ({res_hit, res_miss, res_cfg, res_win, res_addr, res_bus, res_devfn, res_off} !==
            {e.hit, e.miss, e.cfg, e.win, e.addr, e.bus, e.devfn, e.off}) begin
          errors++;
          $display("FAIL %s: got hit=%0d miss=%0d cfg=%0d win=%0d addr=%h bus=%h devfn=%h off=%h expected hit=%0d miss=%0d cfg=%0d win=%0d addr=%h bus=%h devfn=%h off=%h",
                   e.tag, res_hit, res_miss, res_cfg, res_win, res_addr, res_bus, res_devfn, res_off,
                   e.hit, e.miss, e.cfg, e.win, e.addr, e.bus, e.devfn, e.off);
        end
      end
    end
  end

  task automatic wreg(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rreg(input logic [11:0] a, input logic [31:0] exp, input string t);
    @(negedge clk);
    reg_addr = a;
    #1;
    checks++;
    if (reg_rdata !== exp) begin
      errors++;
      $display("FAIL %s: read %h got %h expected %h", t, a, reg_rdata, exp);
    end
  endtask

  task automatic lookup(input logic inb, input logic [63:0] a, input exp_t e);
    @(negedge clk);
    lk_valid = 1'b1; lk_inbound = inb; lk_addr = a;
    q.push_back(e);
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic lookup_with_write(input logic inb, input logic [63:0] a, input exp_t e,
                                   input logic [11:0] ra, input logic [31:0] rd);
    @(negedge clk);
    lk_valid = 1'b1; lk_inbound = inb; lk_addr = a;
    reg_wr = 1'b1; reg_addr = ra; reg_wdata = rd;
    q.push_back(e);
    @(negedge clk);
    lk_valid = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R10: watchdog expired, got running expected finished");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R3 reset state
    @(negedge clk);
    checks++;
    if (res_valid !== 1'b0 || res_hit !== 1'b0 || res_miss !== 1'b0) begin
      errors++;
      $display("FAIL R3: outputs after reset got %b%b%b expected 000", res_valid, res_hit, res_miss);
    end
    rreg(12'h900, 32'h0, "R1");
    wreg(12'h900, 32'h8000_0000);
    rreg(12'h908, 32'h8000_0000, "R3");
    rreg(12'h904, 32'h0, "R3");
    rreg(12'h914, 32'hFFFF_FFFF, "R3");
    wreg(12'h900, 32'h0000_0002);
    rreg(12'h908, 32'h0, "R3");

    // R3 inbound pass-through, R9 outbound miss
    lookup(1, 64'h1234_5678, mk(1, 0, 0, 0, 64'h1234_5678, 0, 0, 0, "R3"));
    lookup(0, 64'h0000_1000, mk(0, 1, 0, 0, 0, 0, 0, 0, "R9"));

    // outbound window 1, staged but not committed (R4)
    wreg(12'h900, 32'h0000_0001);
    wreg(12'h90C, 32'h4000_0000);
    wreg(12'h914, 32'h4FFF_FFFF);
    wreg(12'h918, 32'h0000_1000);
    wreg(12'h91C, 32'h0000_0002);
    lookup(0, 64'h4000_0010, mk(0, 1, 0, 0, 0, 0, 0, 0, "R4"));
    wreg(12'h904, 32'h0);
    wreg(12'h908, 32'h8000_0000);
    lookup(0, 64'h4000_0010, mk(1, 0, 0, 1, 64'h2_0000_1010, 0, 0, 0, "R5"));
    lookup(0, 64'h4FFF_FFFF, mk(1, 0, 0, 1, 64'h2_1000_0FFF, 0, 0, 0, "R5"));
    lookup(0, 64'h5000_0000, mk(0, 1, 0, 0, 0, 0, 0, 0, "R5"));
    lookup(0, 64'h3FFF_FFFF, mk(0, 1, 0, 0, 0, 0, 0, 0, "R5"));

    // R2 readback and half preservation
    rreg(12'h90C, 32'h4000_0000, "R2");
    rreg(12'h910, 32'h0, "R2");
    rreg(12'h918, 32'h0000_1000, "R2");
    rreg(12'h91C, 32'h0000_0002, "R2");
    rreg(12'h908, 32'h8000_0000, "R2");
    wreg(12'h91C, 32'h0000_0003);
    rreg(12'h918, 32'h0000_1000, "R2");
    rreg(12'h91C, 32'h0000_0003, "R2");
    lookup(0, 64'h4000_0010, mk(1, 0, 0, 1, 64'h2_0000_1010, 0, 0, 0, "R4"));
    wreg(12'h908, 32'h8000_0000);
    lookup(0, 64'h4000_0010, mk(1, 0, 0, 1, 64'h3_0000_1010, 0, 0, 0, "R4"));

    // R8 overlapping window 2
    wreg(12'h900, 32'h0000_0002);
    wreg(12'h90C, 32'h4000_0000);
    wreg(12'h914, 32'h4000_FFFF);
    wreg(12'h918, 32'h9000_0000);
    wreg(12'h908, 32'h8000_0000);
    lookup(0, 64'h4000_0010, mk(1, 0, 0, 1, 64'h3_0000_1010, 0, 0, 0, "R8"));

    // R10 commit in the same cycle as a lookup
    wreg(12'h900, 32'h0000_0001);
    lookup_with_write(0, 64'h4000_0010, mk(1, 0, 0, 1, 64'h3_0000_1010, 0, 0, 0, "R10"),
                      12'h908, 32'h0);
    lookup(0, 64'h4000_0010, mk(1, 0, 0, 2, 64'h9000_0010, 0, 0, 0, "R8"));

    // R6 configuration window 0
    wreg(12'h900, 32'h0000_0000);
    wreg(12'h90C, 32'h6000_0000);
    wreg(12'h914, 32'h6FFF_FFFF);
    wreg(12'h918, 32'h0518_0000);
    wreg(12'h904, 32'h0000_0004);
    wreg(12'h908, 32'h8000_0000);
    lookup(0, 64'h6000_0ABC, mk(1, 0, 1, 0, 0, 8'h05, 8'h18, 12'hABC, "R6"));
    lookup(0, 64'h6001_2ABC, mk(1, 0, 1, 0, 0, 8'h05, 8'h18, 12'hABC, "R6"));

    // R7 type switch, visible only after commit
    wreg(12'h904, 32'h0);
    lookup(0, 64'h6000_0ABC, mk(1, 0, 1, 0, 0, 8'h05, 8'h18, 12'hABC, "R7"));
    wreg(12'h908, 32'h8000_0000);
    lookup(0, 64'h6000_0ABC, mk(1, 0, 0, 0, 64'h0518_0ABC, 0, 0, 0, "R7"));

    // R6 inbound ignores type, R8 and R9 inbound behaviour
    wreg(12'h900, 32'h8000_0001);
    wreg(12'h90C, 32'h0);
    wreg(12'h910, 32'h0000_0001);
    wreg(12'h914, 32'h0000_FFFF);
    wreg(12'h918, 32'h8000_0000);
    wreg(12'h904, 32'h0000_0007);
    wreg(12'h908, 32'h8000_0000);
    lookup(1, 64'h1_0000_0020, mk(1, 0, 0, 1, 64'h8000_0020, 0, 0, 0, "R6"));
    lookup(1, 64'h0000_0020, mk(1, 0, 0, 0, 64'h0000_0020, 0, 0, 0, "R8"));
    lookup(1, 64'h1_0001_0000, mk(0, 0, 0, 0, 0, 0, 0, 0, "R9"));

    // R1 out-of-range index
    wreg(12'h900, 32'h0000_0007);
    wreg(12'h90C, 32'h0000_DEAD);
    rreg(12'h90C, 32'h0, "R1");
    rreg(12'h900, 32'h0000_0007, "R1");
    wreg(12'h900, 32'h0000_0003);
    rreg(12'h90C, 32'h0, "R1");
    rreg(12'h914, 32'hFFFF_FFFF, "R3");

    repeat (3) @(negedge clk);
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R10: pending results got %0d expected 0", q.size());
    end
    done = 1;
    finish_run();
  end
endmodule